// File: doc/BRIEF.md
# Standby Entry and Click-Free Output Ramp Controller

This block sequences the power states of a speech playback engine. After a phrase finishes, the engine stays awake for a hold interval so a follow-up request can start quickly. When the hold interval expires, the controller walks the D/A converter input down from mid-scale to zero, one LSB at a time. It then parks in standby, releasing BUSY to high impedance and asking for the oscillator to stop. The gradual walk keeps the speaker from clicking.

A start strobe wakes the block. In stand-alone mode the strobe is chip-select plus start low; in slave mode it is chip-select plus write low. A qualified external reset also wakes the block. On wake the oscillator-stop request drops immediately and the output walks back up to mid-scale. Synthesis is enabled only after a further settling delay. While the controller owns the converter it drives `dac_level` and raises `dac_override`. It releases the converter only while synthesis is running. All durations are parameters counted in clocks.

Top module: `pwr_ramp_ctrl`

## Requirements
- R1: After `rst`, the block is in standby: `dac_level` is 0, `osc_stop_req` is 1, `busy_oe` is 0, `synth_en` is 0, `ramp_active` is 0 and `dac_override` is 1.
- R2: In standby, a wake strobe is `cs_n`=0 together with `st_n`=0 when `slave_mode`=0, or `cs_n`=0 together with `wr_n`=0 when `slave_mode`=1. Any other combination, including the other mode's strobe, is ignored. One clock after a wake strobe is sampled, `osc_stop_req` is 0, `busy_oe` is 1, `busy_n` is 0 and `ramp_active` is 1.
- R3: During the up-ramp, `dac_level` rises by exactly one every STEP_CYC clocks. It reaches 0x100 exactly 256*STEP_CYC clocks after the wake strobe was sampled, and `busy_n` stays 0 throughout.
- R4: `synth_en` rises START_DLY+1 clocks after `dac_level` first reads 0x100. While `synth_en` is 1, `dac_level` is 0x100 and `dac_override` is 0.
- R5: One clock after a `synth_done` pulse, `synth_en` is 0, `busy_n` is 1 and `busy_oe` is 1. `ramp_active` rises exactly HOLD_CYC clocks after that.
- R6: A wake strobe during the hold interval cancels standby entry. `busy_n` goes to 0 on the next clock and `synth_en` rises START_DLY clocks after the strobe. The following hold interval again lasts the full HOLD_CYC clocks.
- R7: During the down-ramp, `dac_level` falls by one every STEP_CYC clocks. One clock after it reaches 0, `osc_stop_req` is 1 and `busy_oe` is 0. `osc_stop_req` is never 1 while `dac_level` is nonzero.
- R8: A wake strobe during the down-ramp reverses the ramp from the present level without any jump. The level never decreases again until 0x100, and synthesis follows.
- R9: In standby, `ext_rst_n` held low for RST_QUAL consecutive clocks starts an up-ramp with `busy_n` left at 1. No synthesis follows, and the block returns to standby through the hold interval and down-ramp. A low run one clock shorter is ignored.
- R10: Wake strobes while the settling delay or synthesis is in progress are ignored: `synth_en` and `busy_n` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slave_mode | input | 1 | 1 selects the write-strobe wake combination |
| cs_n | input | 1 | Chip select, active low |
| st_n | input | 1 | Start strobe, active low (stand-alone mode) |
| wr_n | input | 1 | Write strobe, active low (slave mode) |
| ext_rst_n | input | 1 | Device reset pin, active low, qualified by length |
| synth_done | input | 1 | One-clock pulse when the synthesizer finishes a phrase |
| dac_level | output | 9 | Converter input value driven while overriding |
| dac_override | output | 1 | 1 while this block owns the converter input |
| ramp_active | output | 1 | 1 while the level is ramping up or down |
| synth_en | output | 1 | Permits the synthesizer to run |
| busy_n | output | 1 | BUSY, active low |
| busy_oe | output | 1 | Output enable for BUSY; 0 means high impedance |
| osc_stop_req | output | 1 | Request to stop the clock oscillator |

## Verification
The bench goes after the ramp edges. It counts the exact number of clocks to reach mid-scale and zero. A prescaler that is off by one would stretch or shorten every step and miss the expected totals. A design that did not reverse from the present level during a down-ramp wake would show a jump or a decreasing level, and that would be caught.

The hold interval is measured twice around a cancelling strobe. A timer that was not cleared would fire early on the second hold. The external reset is tried one clock short of qualification and then at exact qualification, which exposes an off-by-one counter. The wrong mode's strobe and strobes during synthesis are applied to show they leave standby and `synth_en` untouched.

// File: rtl/prc_pkg.sv
package prc_pkg;
  typedef enum logic [2:0] {
    PS_SLEEP = 3'd0,
    PS_RISE  = 3'd1,
    PS_DELAY = 3'd2,
    PS_PLAY  = 3'd3,
    PS_IDLE  = 3'd4,
    PS_FALL  = 3'd5
  } prc_state_e;
endpackage

// File: rtl/prc_wake_detect.sv
module prc_wake_detect #(
  parameter int RST_QUAL = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic slave_mode,
  input  logic cs_n,
  input  logic st_n,
  input  logic wr_n,
  input  logic ext_rst_n,
  output logic start_req,
  output logic rst_qual
);
  localparam int QW = $clog2(RST_QUAL + 1);

  logic [QW-1:0] low_cnt_q;

  assign start_req = !cs_n && (slave_mode ? !wr_n : !st_n);

  always_ff @(posedge clk) begin
    if (rst || ext_rst_n) begin
      low_cnt_q <= '0;
    end else if (low_cnt_q != QW'(RST_QUAL)) begin
      low_cnt_q <= low_cnt_q + 1'b1;
    end
  end

  assign rst_qual = !ext_rst_n && (low_cnt_q == QW'(RST_QUAL - 1));

  AST_QUAL_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rst_qual |=> !rst_qual); // R9
endmodule

// File: rtl/prc_ramp_gen.sv
module prc_ramp_gen #(
  parameter int LVL_W    = 9,
  parameter int STEP_CYC = 117
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up,
  input  logic             dn,
  output logic [LVL_W-1:0] level,
  output logic             at_top,
  output logic             at_zero
);
  localparam int PW = $clog2(STEP_CYC + 1);
  localparam logic [LVL_W-1:0] TOP = LVL_W'(1) << (LVL_W - 1);

  logic [PW-1:0]    presc_q;
  logic [LVL_W-1:0] level_q;
  logic             moving;

  assign at_top  = (level_q == TOP);
  assign at_zero = (level_q == '0);
  assign moving  = (up && !at_top) || (dn && !at_zero);

  always_ff @(posedge clk) begin
    if (rst) begin
      presc_q <= '0;
      level_q <= '0;
    end else if (moving) begin
      if (presc_q == PW'(STEP_CYC - 1)) begin
        presc_q <= '0;
        level_q <= up ? level_q + 1'b1 : level_q - 1'b1;
      end else begin
        presc_q <= presc_q + 1'b1;
      end
    end else begin
      presc_q <= '0;
    end
  end

  assign level = level_q;

  AST_LEVEL_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    level_q <= TOP); // R3
  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
    (level_q != $past(level_q)) |->
      ((level_q == $past(level_q) + 1'b1) || (level_q + 1'b1 == $past(level_q)))); // R3
  AST_HOLD_WHEN_STILL: assert property (@(posedge clk) disable iff (rst)
    (!up && !dn) |=> $stable(level_q)); // R7
endmodule

// File: rtl/prc_interval_timer.sv
module prc_interval_timer #(
  parameter int LIMIT = 1408
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign hit = run && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (!hit) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CW'(LIMIT)); // R5
endmodule

// File: rtl/pwr_ramp_ctrl.sv
module pwr_ramp_ctrl #(
  parameter int LVL_W     = 9,
  parameter int STEP_CYC  = 117,
  parameter int HOLD_CYC  = 1920000,
  parameter int START_DLY = 1408,
  parameter int RST_QUAL  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slave_mode,
  input  logic             cs_n,
  input  logic             st_n,
  input  logic             wr_n,
  input  logic             ext_rst_n,
  input  logic             synth_done,
  output logic [LVL_W-1:0] dac_level,
  output logic             dac_override,
  output logic             ramp_active,
  output logic             synth_en,
  output logic             busy_n,
  output logic             busy_oe,
  output logic             osc_stop_req
);
  import prc_pkg::*;

  localparam logic [LVL_W-1:0] MID = LVL_W'(1) << (LVL_W - 1);

  prc_state_e state_q, state_d;
  logic       pend_q, pend_d;
  logic       start_req, rst_qual;
  logic       at_top, at_zero;
  logic       hold_hit, dly_hit;

  prc_wake_detect #(.RST_QUAL(RST_QUAL)) u_wake (
    .clk(clk), .rst(rst), .slave_mode(slave_mode), .cs_n(cs_n),
    .st_n(st_n), .wr_n(wr_n), .ext_rst_n(ext_rst_n),
    .start_req(start_req), .rst_qual(rst_qual)
  );

  prc_ramp_gen #(.LVL_W(LVL_W), .STEP_CYC(STEP_CYC)) u_ramp (
    .clk(clk), .rst(rst),
    .up(state_q == PS_RISE), .dn(state_q == PS_FALL),
    .level(dac_level), .at_top(at_top), .at_zero(at_zero)
  );

  prc_interval_timer #(.LIMIT(HOLD_CYC)) u_hold (
    .clk(clk), .rst(rst), .run(state_q == PS_IDLE), .hit(hold_hit)
  );

  prc_interval_timer #(.LIMIT(START_DLY)) u_settle (
    .clk(clk), .rst(rst), .run(state_q == PS_DELAY), .hit(dly_hit)
  );

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    unique case (state_q)
      PS_SLEEP: begin
        if (start_req) begin
          state_d = PS_RISE;
          pend_d  = 1'b1;
        end else if (rst_qual) begin
          state_d = PS_RISE;
          pend_d  = 1'b0;
        end
      end
      PS_RISE: begin
        if (start_req) pend_d = 1'b1;
        if (at_top) begin
          state_d = (pend_q || start_req) ? PS_DELAY : PS_IDLE;
          pend_d  = 1'b0;
        end
      end
      PS_DELAY: if (dly_hit) state_d = PS_PLAY;
      PS_PLAY:  if (synth_done) state_d = PS_IDLE;
      PS_IDLE: begin
        if (start_req)     state_d = PS_DELAY;
        else if (hold_hit) state_d = PS_FALL;
      end
      PS_FALL: begin
        if (start_req) begin
          state_d = PS_RISE;
          pend_d  = 1'b1;
        end else if (at_zero) begin
          state_d = PS_SLEEP;
        end
      end
      default: state_d = PS_SLEEP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= PS_SLEEP;
      pend_q       <= 1'b0;
      busy_oe      <= 1'b0;
      busy_n       <= 1'b1;
      osc_stop_req <= 1'b1;
      synth_en     <= 1'b0;
      ramp_active  <= 1'b0;
      dac_override <= 1'b1;
    end else begin
      state_q      <= state_d;
      pend_q       <= pend_d;
      busy_oe      <= (state_d != PS_SLEEP);
      busy_n       <= !((state_d == PS_DELAY) || (state_d == PS_PLAY) ||
                        ((state_d == PS_RISE) && pend_d));
      osc_stop_req <= (state_d == PS_SLEEP);
      synth_en     <= (state_d == PS_PLAY);
      ramp_active  <= (state_d == PS_RISE) || (state_d == PS_FALL);
      dac_override <= (state_d != PS_PLAY);
    end
  end

  AST_OSC_ONLY_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    osc_stop_req |-> (dac_level == '0)); // R7
  AST_SYNTH_AT_MID: assert property (@(posedge clk) disable iff (rst)
    synth_en |-> (dac_level == MID)); // R4
  AST_WAKE_EXITS_SLEEP: assert property (@(posedge clk) disable iff (rst)
    (osc_stop_req && start_req) |=> (!osc_stop_req && !busy_n)); // R2
  AST_STROBE_IGNORED_IN_PLAY: assert property (@(posedge clk) disable iff (rst)
    (synth_en && start_req && !synth_done) |=> (synth_en && !busy_n)); // R10
endmodule

// File: tb/pwr_ramp_ctrl_tb_top.sv
module pwr_ramp_ctrl_tb_top;
  localparam int LVL_W = 9;
  localparam int STEP  = 3;
  localparam int HOLD  = 40;
  localparam int START = 7;
  localparam int RSTQ  = 12;
  localparam int MIDV  = 256;
  localparam int RAMP  = 256 * STEP;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slave_mode = 1'b0, cs_n = 1'b1, st_n = 1'b1, wr_n = 1'b1;
  logic ext_rst_n = 1'b1, synth_done = 1'b0;
  logic [LVL_W-1:0] dac_level;
  logic dac_override, ramp_active, synth_en, busy_n, busy_oe, osc_stop_req;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pwr_ramp_ctrl #(.LVL_W(LVL_W), .STEP_CYC(STEP), .HOLD_CYC(HOLD),
                  .START_DLY(START), .RST_QUAL(RSTQ)) dut_i (
    .clk(clk), .rst(rst), .slave_mode(slave_mode), .cs_n(cs_n), .st_n(st_n),
    .wr_n(wr_n), .ext_rst_n(ext_rst_n), .synth_done(synth_done),
    .dac_level(dac_level), .dac_override(dac_override),
    .ramp_active(ramp_active), .synth_en(synth_en), .busy_n(busy_n),
    .busy_oe(busy_oe), .osc_stop_req(osc_stop_req)
  );

  task automatic tk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic pulse_wake();
    cs_n = 1'b0;
    if (slave_mode) wr_n = 1'b0; else st_n = 1'b0;
    tk(1);
    cs_n = 1'b1; st_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic pulse_done();
    synth_done = 1'b1;
    tk(1);
    synth_done = 1'b0;
  endtask

  // Rise to mid-scale from the current sample; counts clocks and bad steps.
  task automatic rise(output int n, output int bad, output int busy_hi);
    int prev;
    n = 0; bad = 0; busy_hi = 0; prev = int'(dac_level);
    while (int'(dac_level) != MIDV && n < 4 * RAMP) begin
      tk(1); n++;
      if (int'(dac_level) < prev) bad++;
      if (busy_n) busy_hi++;
      prev = int'(dac_level);
    end
  endtask

  // From the hold state into standby; returns clocks of hold and of fall.
  task automatic hold_and_fall(output int h, output int f, output int bad);
    int prev;
    h = 0; f = 0; bad = 0;
    while (!ramp_active && h < 4 * HOLD) begin tk(1); h++; end
    prev = int'(dac_level);
    while (!osc_stop_req && f < 4 * RAMP) begin
      tk(1); f++;
      if (int'(dac_level) != prev && (int'(dac_level) + 1 != prev || (f % STEP) != 0)) bad++;
      if (osc_stop_req && dac_level != 0) bad++;
      prev = int'(dac_level);
    end
  endtask

  task automatic wait_synth(output int m);
    m = 0;
    while (!synth_en && m < 4 * START + 10) begin tk(1); m++; end
  endtask

  task automatic t_reset();
    rst = 1'b1; tk(3); rst = 1'b0; tk(1);
    chk("R1 level", int'(dac_level), 0);
    chk("R1 osc_stop_req", int'(osc_stop_req), 1);
    chk("R1 busy_oe", int'(busy_oe), 0);
    chk("R1 synth_en", int'(synth_en), 0);
    chk("R1 ramp_active", int'(ramp_active), 0);
    chk("R1 dac_override", int'(dac_override), 1);
    // R2: the slave strobe and a bare start are ignored in stand-alone mode
    cs_n = 1'b0; wr_n = 1'b0; tk(1); cs_n = 1'b1; wr_n = 1'b1; tk(1);
    chk("R2 wr strobe ignored in stand-alone", int'(osc_stop_req), 1);
    st_n = 1'b0; tk(1); st_n = 1'b1; tk(1);
    chk("R2 st without cs ignored", int'(osc_stop_req), 1);
  endtask

  task automatic t_wake_play();
    int n, bad, bh, m, h, f, fb, prev, steps_bad;
    pulse_wake();
    chk("R2 osc cleared", int'(osc_stop_req), 0);
    chk("R2 busy_oe", int'(busy_oe), 1);
    chk("R2 busy_n low", int'(busy_n), 0);
    chk("R2 ramp_active", int'(ramp_active), 1);
    // R3: timing of each step
    n = 0; steps_bad = 0; bh = 0; prev = int'(dac_level);
    while (int'(dac_level) != MIDV && n < 4 * RAMP) begin
      tk(1); n++;
      if (int'(dac_level) != prev && (int'(dac_level) != prev + 1 || (n % STEP) != 0)) steps_bad++;
      if (busy_n) bh++;
      prev = int'(dac_level);
    end
    chk("R3 up-ramp clocks", n, RAMP);
    chk("R3 step spacing errors", steps_bad, 0);
    chk("R3 busy_n high during ramp", bh, 0);
    wait_synth(m);
    chk("R4 settle clocks", m, START + 1);
    chk("R4 override released", int'(dac_override), 0);
    chk("R4 level at mid", int'(dac_level), MIDV);
    // R10: strobe during synthesis
    pulse_wake();
    chk("R10 synth_en kept", int'(synth_en), 1);
    tk(3);
    chk("R10 busy_n kept", int'(busy_n), 0);
    pulse_done();
    chk("R5 synth_en off", int'(synth_en), 0);
    chk("R5 busy_n high", int'(busy_n), 1);
    chk("R5 busy_oe", int'(busy_oe), 1);
    hold_and_fall(h, f, fb);
    chk("R5 hold clocks", h, HOLD);
    chk("R7 fall clocks", f, RAMP + 1);
    chk("R7 fall step errors", fb, 0);
    chk("R7 busy_oe released", int'(busy_oe), 0);
    chk("R7 level zero", int'(dac_level), 0);
    n = bad;
  endtask

  task automatic t_cancel();
    int n, bad, bh, m, h, f, fb;
    pulse_wake(); rise(n, bad, bh); wait_synth(m); pulse_done();
    tk(HOLD - 5);
    chk("R6 still holding", int'(ramp_active), 0);
    pulse_wake();
    chk("R6 busy_n low", int'(busy_n), 0);
    chk("R6 no ramp", int'(ramp_active), 0);
    wait_synth(m);
    chk("R6 settle clocks", m, START);
    pulse_done();
    hold_and_fall(h, f, fb);
    chk("R6 second hold full", h, HOLD);
    chk("R6 back in standby", int'(osc_stop_req), 1);
  endtask

  task automatic t_reverse();
    int n, bad, bh, m, lvl;
    pulse_wake(); rise(n, bad, bh); wait_synth(m); pulse_done();
    while (!ramp_active) tk(1);
    tk(100);
    lvl = int'(dac_level);
    pulse_wake();
    chk("R8 ramp active", int'(ramp_active), 1);
    chk("R8 busy_n low", int'(busy_n), 0);
    chk("R8 no jump", int'(int'(dac_level) >= lvl - 1 && int'(dac_level) <= lvl), 1);
    rise(n, bad, bh);
    chk("R8 level decreases", bad, 0);
    chk("R8 reached mid", int'(dac_level), MIDV);
    wait_synth(m);
    chk("R8 synthesis follows", int'(synth_en), 1);
    pulse_done();
    hold_and_fall(n, m, bad);
  endtask

  task automatic t_slave();
    int n, bad, bh, m;
    slave_mode = 1'b1;
    cs_n = 1'b0; st_n = 1'b0; tk(1); cs_n = 1'b1; st_n = 1'b1; tk(2);
    chk("R2 st ignored in slave mode", int'(osc_stop_req), 1);
    pulse_wake();
    chk("R2 slave wake busy_n", int'(busy_n), 0);
    chk("R2 slave wake osc", int'(osc_stop_req), 0);
    rise(n, bad, bh); wait_synth(m); pulse_done();
    hold_and_fall(n, m, bad);
    slave_mode = 1'b0;
  endtask

  task automatic t_ext_reset();
    int n, bad, bh, syn;
    ext_rst_n = 1'b0; tk(RSTQ - 1); ext_rst_n = 1'b1; tk(2);
    chk("R9 short reset ignored", int'(osc_stop_req), 1);
    chk("R9 short reset no ramp", int'(ramp_active), 0);
    ext_rst_n = 1'b0; tk(RSTQ);
    chk("R9 ramp started", int'(ramp_active), 1);
    chk("R9 osc cleared", int'(osc_stop_req), 0);
    chk("R9 busy_n stays high", int'(busy_n), 1);
    ext_rst_n = 1'b1;
    rise(n, bad, bh);
    syn = 0;
    n = 0;
    while (!osc_stop_req && n < 4 * RAMP + 4 * HOLD) begin
      tk(1); n++;
      if (synth_en) syn++;
    end
    chk("R9 no synthesis", syn, 0);
    chk("R9 returned to standby", int'(osc_stop_req), 1);
  endtask

  initial begin
    tk(1);
    t_reset();
    t_wake_play();
    t_cancel();
    t_reverse();
    t_slave();
    t_ext_reset();
    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
    $finish;
  end
endmodule